// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog timer seen by software as a small set of byte registers on a simple write/read bus. When armed, it advances a 16-bit count on each pulse of a slow tick strobe. It raises a pending flag, and optionally an interrupt, once the count has covered half of the programmed limit. When the count reaches the limit it issues a one-cycle reset request. A reset-scope code travels with that request.

Firmware keeps the watchdog alive by writing the arm bit again, which restarts the count. The arm bit can only be cleared by a write that also carries a 4-bit key in its upper nibble, so a stray write of zero cannot stop the watchdog. Four scratch bytes let firmware note which task last refreshed the timer. The tick comes from one of two strobe inputs, chosen by a configuration bit. A limit below three is raised to three, so the half-way point always falls before the end point.

Top module: `pwd_watchdog`

## Requirements
- R1: After reset the watchdog is disarmed, every register reads 0 except the limit, which reads 0xFFFF (offset 0x0C low byte, 0x0D high byte), and irq_o, rst_req_o and rst_type_o are low.
- R2: Writing offset 0x00 with bit 0 set arms the watchdog. Bit 1 picks the tick: 0 selects tick_sleep_i and 1 selects tick_periph_i. Pulses on the input that is not selected do not advance the count. Offset 0x00 reads back as {6'b0, bit1, bit0}.
- R3: A write to offset 0x00 with bit 0 clear disarms only when bits 7:4 equal 4'b1001. With any other upper nibble the watchdog stays armed.
- R4: Writing bit 0 = 1 to offset 0x00 while the watchdog is armed restarts the count from zero. This also applies after the count has ended, in which case counting resumes.
- R5: On the tick that brings the count to (effective limit >> 1), pending bit 0 (offset 0x08) sets.
- R6: On the tick that brings the count to the effective limit, pending bit 1 sets and rst_req_o is high for exactly one cycle. The count then stops until the watchdog is re-armed.
- R7: The effective limit is the programmed limit, or 3 if the programmed limit is below 3.
- R8: Writing 1 to a pending bit clears it, and writing 0 leaves it unchanged. A flag that sets in the same cycle as its clear stays set.
- R9: irq_o is high exactly while pending bit 0 and interrupt-enable bit 0 (offset 0x04) are both set.
- R10: rst_type_o always equals bits 1:0 of offset 0x01. The codes are 0 for the whole chip except GPIO, 1 for the whole chip, and 2 for the core only.
- R11: Offsets 0x10 to 0x13 are four independent read/write scratch bytes.
- R12: rdata_o presents the addressed register in the cycle after rd_en_i. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_sleep_i | input | 1 | Tick strobe used when config bit 1 is 0 |
| tick_periph_i | input | 1 | Tick strobe used when config bit 1 is 1 |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 5 | Byte offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, one cycle after rd_en_i |
| irq_o | output | 1 | Half-way interrupt |
| rst_req_o | output | 1 | One-cycle reset request |
| rst_type_o | output | RTYPE_W | Reset scope code |

## Verification
The checker assumes that addr_i and wdata_i are meaningful in every cycle where wr_en_i is high. It also assumes that each tick strobe is a one-cycle pulse, so a reset request can always be traced back to a tick in the cycle before it. The bench drives every bus access and every tick as a single-cycle pulse set up on the falling edge. It never overlaps a tick with a register write, so the intended count value at each flag is unambiguous.

// File: rtl/pwd_watchdog_pkg.sv
package pwd_watchdog_pkg;
  localparam int unsigned ADDR_W = 5;
  localparam logic [ADDR_W-1:0] OFS_CFG      = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_RTYPE    = 5'h01;
  localparam logic [ADDR_W-1:0] OFS_IE       = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_PEND     = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_LIMIT_LO = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_LIMIT_HI = 5'h0D;
  localparam logic [ADDR_W-1:0] OFS_SCR0     = 5'h10;
  localparam logic [3:0]        DISARM_KEY   = 4'h9;

  typedef struct packed {
    logic src;
    logic en;
  } cfg_t;
endpackage

// File: rtl/pwd_watchdog_regs.sv
module pwd_watchdog_regs
  import pwd_watchdog_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned RTYPE_W = 2,
  parameter int unsigned NUM_SCR = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [7:0]         wdata,
  input  logic               half_hit,
  input  logic               end_hit,
  output logic [7:0]         rdata,
  output cfg_t               cfg,
  output logic               ie,
  output logic [1:0]         pend,
  output logic [CNT_W-1:0]   limit,
  output logic [RTYPE_W-1:0] rtype,
  output logic               restart
);
  localparam int unsigned HI_W      = CNT_W - 8;
  localparam int unsigned SCR_IDX_W = (NUM_SCR > 1) ? $clog2(NUM_SCR) : 1;

  logic cfg_wr, disarm_ok, pend_wr;
  logic [7:0] scr_q [NUM_SCR];
  logic [7:0] rd_mux;
  logic [ADDR_W-1:0] scr_off;
  logic [15:0] limit16;

  assign cfg_wr    = wr_en && (addr == OFS_CFG);
  assign restart   = cfg_wr && wdata[0];
  assign disarm_ok = cfg_wr && !wdata[0] && (wdata[7:4] == DISARM_KEY);
  assign pend_wr   = wr_en && (addr == OFS_PEND);
  assign scr_off   = addr - OFS_SCR0;
  assign limit16   = 16'(limit);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= '0;
    end else begin
      if (cfg_wr) cfg.src <= wdata[1];
      if (restart) cfg.en <= 1'b1;
      else if (disarm_ok) cfg.en <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ie    <= 1'b0;
      rtype <= '0;
      limit <= '1;
    end else if (wr_en) begin
      if (addr == OFS_IE) ie <= wdata[0];
      if (addr == OFS_RTYPE) rtype <= wdata[RTYPE_W-1:0];
      if (addr == OFS_LIMIT_LO) limit[7:0] <= wdata;
      if (addr == OFS_LIMIT_HI) limit[CNT_W-1:8] <= wdata[HI_W-1:0];
    end
  end

  // Set has priority over a same-cycle write-one clear
  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 2'b00;
    end else begin
      pend[0] <= half_hit | (pend[0] & ~(pend_wr & wdata[0]));
      pend[1] <= end_hit  | (pend[1] & ~(pend_wr & wdata[1]));
    end
  end

  for (genvar i = 0; i < NUM_SCR; i++) begin : g_scr
    always_ff @(posedge clk) begin
      if (rst) scr_q[i] <= 8'h00;
      else if (wr_en && (addr == OFS_SCR0 + ADDR_W'(i))) scr_q[i] <= wdata;
    end
  end

  always_comb begin
    rd_mux = 8'h00;
    case (addr)
      OFS_CFG:      rd_mux = {6'b0, cfg.src, cfg.en};
      OFS_RTYPE:    rd_mux = 8'(rtype);
      OFS_IE:       rd_mux = {7'b0, ie};
      OFS_PEND:     rd_mux = {6'b0, pend};
      OFS_LIMIT_LO: rd_mux = limit16[7:0];
      OFS_LIMIT_HI: rd_mux = limit16[15:8];
      default: begin
        if (scr_off < ADDR_W'(NUM_SCR)) rd_mux = scr_q[scr_off[SCR_IDX_W-1:0]];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= 8'h00;
    else if (rd_en) rdata <= rd_mux;
  end
endmodule

// File: rtl/pwd_watchdog_counter.sv
module pwd_watchdog_counter #(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned MIN_LIMIT = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             restart,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic             half_hit,
  output logic             end_hit,
  output logic             req,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] MIN_L = CNT_W'(MIN_LIMIT);

  logic [CNT_W-1:0] eff, half, cnt_nx;
  logic halted, step;

  assign eff    = (limit < MIN_L) ? MIN_L : limit;
  assign half   = eff >> 1;
  assign cnt_nx = cnt + 1'b1;
  assign step   = en && !restart && !halted && tick;

  assign half_hit = step && (cnt_nx == half);
  assign end_hit  = step && (cnt_nx >= eff);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      halted <= 1'b0;
      req    <= 1'b0;
    end else begin
      req <= 1'b0;
      if (restart || !en) begin
        cnt    <= '0;
        halted <= 1'b0;
      end else if (step) begin
        cnt <= cnt_nx;
        if (end_hit) begin
          halted <= 1'b1;
          req    <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pwd_watchdog.sv
module pwd_watchdog
  import pwd_watchdog_pkg::*;
#(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned RTYPE_W   = 2,
  parameter int unsigned NUM_SCR   = 4,
  parameter int unsigned MIN_LIMIT = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick_sleep_i,
  input  logic               tick_periph_i,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  logic [4:0]         addr_i,
  input  logic [7:0]         wdata_i,
  output logic [7:0]         rdata_o,
  output logic               irq_o,
  output logic               rst_req_o,
  output logic [RTYPE_W-1:0] rst_type_o
);
  cfg_t cfg;
  logic ie, restart, half_hit, end_hit, tick;
  logic [1:0] pend;
  logic [CNT_W-1:0] limit, count_w;

  assign tick = cfg.src ? tick_periph_i : tick_sleep_i;

  pwd_watchdog_regs #(
    .CNT_W(CNT_W), .RTYPE_W(RTYPE_W), .NUM_SCR(NUM_SCR)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en_i), .rd_en(rd_en_i),
    .addr(addr_i), .wdata(wdata_i), .half_hit(half_hit), .end_hit(end_hit),
    .rdata(rdata_o), .cfg(cfg), .ie(ie), .pend(pend), .limit(limit),
    .rtype(rst_type_o), .restart(restart)
  );

  pwd_watchdog_counter #(
    .CNT_W(CNT_W), .MIN_LIMIT(MIN_LIMIT)
  ) u_cnt (
    .clk(clk), .rst(rst), .en(cfg.en), .restart(restart), .tick(tick),
    .limit(limit), .half_hit(half_hit), .end_hit(end_hit),
    .req(rst_req_o), .cnt(count_w)
  );

  assign irq_o = pend[0] & ie;
endmodule

// File: rtl/pwd_watchdog_chk.sv
module pwd_watchdog_chk
  import pwd_watchdog_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [4:0]       addr,
  input logic [7:0]       wdata,
  input logic             en,
  input logic             tick,
  input logic [1:0]       pend,
  input logic [CNT_W-1:0] cnt,
  input logic             req
);
  AST_KEY_REQUIRED: assert property (@(posedge clk) disable iff (rst)
    (en && wr_en && addr == OFS_CFG && !wdata[0] && wdata[7:4] != DISARM_KEY) |=> en); // R3
  AST_KICK_ZEROES: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == OFS_CFG && wdata[0]) |=> (cnt == '0)); // R4
  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    req |=> !req); // R6
  AST_REQ_FLAGGED: assert property (@(posedge clk) disable iff (rst)
    req |-> pend[1]); // R6
  AST_REQ_FROM_TICK: assert property (@(posedge clk) disable iff (rst)
    req |-> $past(tick)); // R2
endmodule

bind pwd_watchdog pwd_watchdog_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en_i), .addr(addr_i), .wdata(wdata_i),
  .en(cfg.en), .tick(tick), .pend(pend), .cnt(count_w), .req(rst_req_o)
);

// File: tb/pwd_watchdog_tb.sv
module pwd_watchdog_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ts = 1'b0, tp = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic irq, req;
  logic [1:0] rtype;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pwd_watchdog u_dut (
    .clk(clk), .rst(rst), .tick_sleep_i(ts), .tick_periph_i(tp),
    .wr_en_i(wr), .rd_en_i(rd), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq), .rst_req_o(req), .rst_type_o(rtype)
  );

  task automatic chk(input string r, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic bw(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic br(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); rd = 1'b1; addr = a;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic tk(input bit periph);
    @(negedge clk); if (periph) tp = 1'b1; else ts = 1'b1;
    @(negedge clk); tp = 1'b0; ts = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 irq", 16'(irq), 0); chk("R1 req", 16'(req), 0); chk("R1 type", 16'(rtype), 0);
    br(5'h00, d); chk("R1 cfg", 16'(d), 0);
    br(5'h08, d); chk("R1 pend", 16'(d), 0);
    br(5'h0C, d); chk("R1 limit lo", 16'(d), 16'hFF);
    br(5'h0D, d); chk("R1 limit hi", 16'(d), 16'hFF);
    br(5'h12, d); chk("R1 scratch", 16'(d), 0);
    br(5'h02, d); chk("R12 reserved", 16'(d), 0);
  endtask

  task automatic t_main();
    logic [7:0] d;
    bw(5'h0C, 8'd8); bw(5'h0D, 8'd0); bw(5'h04, 8'h01);
    bw(5'h01, 8'h02); chk("R10 type", 16'(rtype), 2);
    bw(5'h00, 8'h03);
    br(5'h00, d); chk("R2 cfg readback", 16'(d), 3);
    for (int i = 0; i < 5; i++) tk(0);
    br(5'h08, d); chk("R2 other source ignored", 16'(d), 0);
    for (int i = 0; i < 3; i++) tk(1);
    br(5'h08, d); chk("R5 no half yet", 16'(d), 0);
    tk(1);
    br(5'h08, d); chk("R5 half set", 16'(d), 1);
    chk("R9 irq on", 16'(irq), 1);
    for (int i = 0; i < 3; i++) tk(1);
    chk("R6 no req early", 16'(req), 0);
    tk(1);
    chk("R6 req pulse", 16'(req), 1);
    @(negedge clk); chk("R6 req one cycle", 16'(req), 0);
    br(5'h08, d); chk("R6 both flags", 16'(d), 3);
    for (int i = 0; i < 3; i++) begin tk(1); chk("R6 halted", 16'(req), 0); end
  endtask

  task automatic t_w1c();
    logic [7:0] d;
    bw(5'h08, 8'h00); br(5'h08, d); chk("R8 zero write", 16'(d), 3);
    bw(5'h08, 8'h01); br(5'h08, d); chk("R8 clear half", 16'(d), 2);
    chk("R9 irq off", 16'(irq), 0);
    bw(5'h08, 8'h02); br(5'h08, d); chk("R8 clear end", 16'(d), 0);
  endtask

  task automatic t_kick();
    logic [7:0] d;
    bw(5'h00, 8'h01); bw(5'h04, 8'h00);
    for (int i = 0; i < 3; i++) tk(0);
    bw(5'h00, 8'h01);
    for (int i = 0; i < 3; i++) tk(0);
    br(5'h08, d); chk("R4 restart delays half", 16'(d), 0);
    tk(0);
    br(5'h08, d); chk("R4 half after restart", 16'(d), 1);
    chk("R9 irq masked", 16'(irq), 0);
    for (int i = 0; i < 3; i++) tk(0);
    chk("R4 no req early", 16'(req), 0);
    tk(0); chk("R4 resumed after end", 16'(req), 1);
    bw(5'h08, 8'h03);
  endtask

  task automatic t_password();
    logic [7:0] d;
    bw(5'h00, 8'h00); br(5'h00, d); chk("R3 plain clear ignored", 16'(d), 1);
    bw(5'h00, 8'h80); br(5'h00, d); chk("R3 wrong key ignored", 16'(d), 1);
    bw(5'h00, 8'h90); br(5'h00, d); chk("R3 key disarms", 16'(d), 0);
    for (int i = 0; i < 10; i++) tk(0);
    br(5'h08, d); chk("R3 disarmed no count", 16'(d), 0);
  endtask

  task automatic t_clamp();
    logic [7:0] d;
    bw(5'h0C, 8'd1); bw(5'h00, 8'h01);
    tk(0); br(5'h08, d); chk("R7 half at one", 16'(d), 1);
    tk(0); chk("R7 no req at two", 16'(req), 0);
    tk(0); chk("R7 req at three", 16'(req), 1);
    bw(5'h00, 8'h90); bw(5'h08, 8'h03);
  endtask

  task automatic t_scratch();
    logic [7:0] d;
    for (int i = 0; i < 4; i++) bw(5'(5'h10 + i), 8'(8'hA5 + i));
    for (int i = 0; i < 4; i++) begin
      br(5'(5'h10 + i), d); chk("R11 scratch", 16'(d), 16'(8'hA5 + i));
    end
    br(5'h14, d); chk("R12 past scratch", 16'(d), 0);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_main();
    t_w1c();
    t_kick();
    t_password();
    t_clamp();
    t_scratch();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule